// File: doc/BRIEF.md
# Serial-Loaded Multichannel Trim Register Bank

This block is the digital front end of a twelve-channel, 8-bit converter that stands in for mechanical trimmers. A host writes the bank over a three-wire serial link made of a data line, a serial clock and an active-low select. While select is low, each rising serial-clock edge shifts one bit into a 12-bit frame register. When select is released, the frame is decoded into a 4-bit channel address and an 8-bit code. The addressed code register then takes the new value. Every code is presented on a flat parallel output that feeds the analog converters.

The serial clock, select and data line are first brought into the system clock domain through two-flop synchronizers. A small receive state machine then processes the frame. It has three states. RX_IDLE holds the bit counter at zero while select is high, and leaves for RX_SHIFT once the synchronized select reads low. RX_SHIFT shifts on each detected serial-clock rise, with the counter saturating at twelve, and moves to RX_COMMIT when select reads high again. RX_COMMIT lasts one cycle. It issues a write only if a full frame was seen, then returns to RX_IDLE.

The code registers are reset to mid-scale in two ways: asynchronously by the power-on reset, and by a separate active-low preset input. An active-low shutdown request passes straight through to the analog section and leaves the stored codes alone.

Top module: `serial_trim_bank`

## Requirements
- R1: A frame is sent as four address bits and then eight data bits, each field most significant bit first. The first bit shifted in is address bit 3 and the last is data bit 0.
- R2: When select rises, the code for channel index k (address k, for k from 0 to 11) takes the frame's data bits. Channel k appears on `codes[8k+7:8k]`.
- R3: A frame changes at most one channel. Every other channel keeps its value.
- R4: The codes change only after select rises. Serial-clock edges while select is high have no effect. While select is still low, the codes stay unchanged.
- R5: While `preset_n` is low, every channel reads 8'h80. This takes effect without waiting for a clock edge.
- R6: After power-on reset (`rst_n` low), every channel reads 8'h80.
- R7: When more than twelve serial-clock rises occur during one select-low window, only the last twelve bits form the frame.
- R8: A frame with fewer than twelve serial-clock rises since select fell changes no channel.
- R9: A frame whose address is 0xC to 0xF changes no channel.
- R10: `pd_n` follows `shdn_n`. Asserting shutdown leaves every channel code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| preset_n | input | 1 | Asynchronous mid-scale preset of all channels, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data line |
| cs_n | input | 1 | Select, active low; its rising edge commits the frame |
| shdn_n | input | 1 | Analog shutdown request, active low |
| codes | output | NUM_CH*CODE_W (96) | Channel codes, channel k in bits [8k+7:8k] |
| pd_n | output | 1 | Shutdown request passed to the analog section |

## Verification
The bench builds the block with its default parameters: twelve channels, 8-bit codes and a 4-bit address. With these values, four address codes (0xC to 0xF) fall outside the channel range. This lets the bench show that such frames are dropped, and that channel 11 is written at the exact boundary. It also brings within reach over-long frames of sixteen bits and short frames of eleven bits, and the asynchronous preset arriving between frames.

// File: rtl/trim_pkg.sv
package trim_pkg;
    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_SHIFT  = 2'd1,
        RX_COMMIT = 2'd2
    } rx_state_t;
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/trim_frame_rx.sv
module trim_frame_rx
    import trim_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_low,
    input  logic              sclk_rise,
    input  logic              sdi_bit,
    output logic              commit,
    output logic [ADDR_W-1:0] addr,
    output logic [CODE_W-1:0] data
);
    localparam int FRAME_W = ADDR_W + CODE_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    rx_state_t        state, state_nx;
    logic [FRAME_W-1:0] frame_sr;
    logic [CNT_W-1:0]   bit_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:   if (sel_low)  state_nx = RX_SHIFT;
            RX_SHIFT:  if (!sel_low) state_nx = RX_COMMIT;
            RX_COMMIT: state_nx = RX_IDLE;
            default:   state_nx = RX_IDLE;
        endcase
    end

    // frame shifter and saturating bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_sr <= '0;
            bit_cnt  <= '0;
        end else if (state == RX_IDLE) begin
            bit_cnt <= '0;
        end else if (state == RX_SHIFT && sclk_rise) begin
            frame_sr <= {frame_sr[FRAME_W-2:0], sdi_bit};
            if (bit_cnt != CNT_FULL) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        commit = (state == RX_COMMIT) && (bit_cnt == CNT_FULL);
        addr   = frame_sr[FRAME_W-1:CODE_W];
        data   = frame_sr[CODE_W-1:0];
    end
endmodule

// File: rtl/trim_regs.sv
module trim_regs #(
    parameter int              NUM_CH   = 12,
    parameter int              CODE_W   = 8,
    parameter int              ADDR_W   = 4,
    parameter logic [CODE_W-1:0] MID_CODE = 8'h80
) (
    input  logic                     clk,
    input  logic                     clr_n,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [CODE_W-1:0]        wdata,
    output logic [NUM_CH*CODE_W-1:0] codes
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CODE_W-1:0] code_q;

        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)                              code_q <= MID_CODE;
            else if (wr && waddr == ADDR_W'(ch))     code_q <= wdata;
        end

        assign codes[ch*CODE_W +: CODE_W] = code_q;
    end
endmodule

// File: rtl/serial_trim_bank.sv
module serial_trim_bank #(
    parameter int              NUM_CH   = 12,
    parameter int              CODE_W   = 8,
    parameter int              ADDR_W   = 4,
    parameter logic [CODE_W-1:0] MID_CODE = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     preset_n,
    input  logic                     sclk,
    input  logic                     sdi,
    input  logic                     cs_n,
    input  logic                     shdn_n,
    output logic [NUM_CH*CODE_W-1:0] codes,
    output logic                     pd_n
);
    logic [2:0]        pins_s;
    logic              sclk_d;
    logic              sclk_rise;
    logic              frame_commit;
    logic [ADDR_W-1:0] frame_addr;
    logic [CODE_W-1:0] frame_data;
    logic              bank_clr_n;

    // bit 2: sclk, bit 1: cs_n (idle high), bit 0: sdi
    trim_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, cs_n, sdi}),
        .q     (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= pins_s[2];
    end

    assign sclk_rise = pins_s[2] & ~sclk_d;

    trim_frame_rx #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_low   (~pins_s[1]),
        .sclk_rise (sclk_rise),
        .sdi_bit   (pins_s[0]),
        .commit    (frame_commit),
        .addr      (frame_addr),
        .data      (frame_data)
    );

    assign bank_clr_n = rst_n & preset_n;

    trim_regs #(
        .NUM_CH   (NUM_CH),
        .CODE_W   (CODE_W),
        .ADDR_W   (ADDR_W),
        .MID_CODE (MID_CODE)
    ) u_regs (
        .clk   (clk),
        .clr_n (bank_clr_n),
        .wr    (frame_commit),
        .waddr (frame_addr),
        .wdata (frame_data),
        .codes (codes)
    );

    assign pd_n = shdn_n;
endmodule

// File: rtl/serial_trim_bank_chk.sv
module serial_trim_bank_chk #(
    parameter int              NUM_CH   = 12,
    parameter int              CODE_W   = 8,
    parameter int              ADDR_W   = 4,
    parameter logic [CODE_W-1:0] MID_CODE = 8'h80
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     preset_n,
    input logic                     cs_n,
    input logic [NUM_CH*CODE_W-1:0] codes,
    input logic                     commit,
    input logic [ADDR_W-1:0]        addr,
    input logic [CODE_W-1:0]        data
);
    logic [NUM_CH*CODE_W-1:0] codes_prev;
    logic [NUM_CH-1:0]        ch_moved;

    always_ff @(posedge clk) codes_prev <= codes;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
        assign ch_moved[ch] = codes[ch*CODE_W +: CODE_W] != codes_prev[ch*CODE_W +: CODE_W];
    end

    function automatic logic [CODE_W-1:0] pick(input logic [NUM_CH*CODE_W-1:0] v,
                                               input logic [ADDR_W-1:0] a);
        return CODE_W'(v >> (int'(a) * CODE_W));
    endfunction

    AST_PRESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_n |-> codes == {NUM_CH{MID_CODE}}); // R5

    AST_SINGLE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && $past(preset_n)) |-> $countones(ch_moved) <= 1); // R3

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)
         && $past(cs_n, 5) && $past(cs_n, 6) && preset_n && $past(preset_n))
        |-> $stable(codes)); // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && preset_n && int'(addr) < NUM_CH)
        |=> (!preset_n || pick(codes, $past(addr)) == $past(data))); // R2
endmodule

bind serial_trim_bank serial_trim_bank_chk #(
    .NUM_CH   (NUM_CH),
    .CODE_W   (CODE_W),
    .ADDR_W   (ADDR_W),
    .MID_CODE (MID_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset_n (preset_n),
    .cs_n     (cs_n),
    .codes    (codes),
    .commit   (frame_commit),
    .addr     (frame_addr),
    .data     (frame_data)
);

// File: tb/serial_trim_bank_tb.sv
module serial_trim_bank_tb;
    localparam int NCH = 12;
    localparam int NV  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, preset_n = 1'b1, sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, shdn_n = 1'b1;
    logic [NCH*8-1:0] codes;
    logic pd_n;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_code [NCH];

    always #5 clk = ~clk;

    serial_trim_bank u_dut (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .sclk(sclk), .sdi(sdi),
        .cs_n(cs_n), .shdn_n(shdn_n), .codes(codes), .pd_n(pd_n)
    );

    // vector table: address, data, serial clocks sent
    localparam logic [3:0] V_ADDR [NV] = '{4'd0, 4'd11, 4'd5, 4'd3, 4'd12, 4'd15, 4'd7, 4'd7};
    localparam logic [7:0] V_DATA [NV] = '{8'h12, 8'hFE, 8'h00, 8'hFF, 8'h55, 8'hAA, 8'h3C, 8'hC3};
    localparam int         V_NBIT [NV] = '{12, 12, 12, 16, 12, 12, 11, 12};

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            wait_clk(3);
            sclk = 1'b1;
            wait_clk(3);
            sclk = 1'b0;
            wait_clk(2);
        end
    endtask

    task automatic send(input logic [3:0] a, input logic [7:0] d, input int n);
        logic [15:0] bits;
        if (n >= 12) bits = {4'hA, a, d};        // extra leading bits precede the frame
        else         bits = 16'({a, d}) >> (12 - n);
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(4);
        shift_bits(bits, n);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic check_all(input string tag);
        for (int ch = 0; ch < NCH; ch++) begin
            checks++;
            if (codes[ch*8 +: 8] !== exp_code[ch]) begin
                fails++;
                $display("FAIL %s ch%0d: got %h expected %h", tag, ch, codes[ch*8 +: 8], exp_code[ch]);
            end
        end
    endtask

    task automatic set_mid();
        for (int ch = 0; ch < NCH; ch++) exp_code[ch] = 8'h80;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        set_mid();
        wait_clk(5);
        check_all("R6 power-on mid-code");
        rst_n = 1'b1;
        wait_clk(3);
        check_all("R6 after reset release");

        // table walk: R1 bit order, R2 decode, R3 single channel, R7 long, R8 short, R9 bad address
        for (int v = 0; v < NV; v++) begin
            send(V_ADDR[v], V_DATA[v], V_NBIT[v]);
            if (V_NBIT[v] >= 12 && int'(V_ADDR[v]) < NCH) exp_code[V_ADDR[v]] = V_DATA[v];
            check_all($sformatf("R1/R2/R3/R7/R8/R9 vector %0d", v));
        end

        // R4: serial clocks with select high do nothing
        for (int i = 0; i < 14; i++) begin
            sdi = i[0];
            wait_clk(3); sclk = 1'b1; wait_clk(3); sclk = 1'b0;
        end
        wait_clk(10);
        check_all("R4 clocks with select high");

        // R4: full frame shifted but select not yet released
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(4);
        shift_bits({4'h0, 4'd2, 8'h99}, 12);
        wait_clk(10);
        check_all("R4 before select rise");
        cs_n = 1'b1;
        wait_clk(12);
        exp_code[2] = 8'h99;
        check_all("R4 after select rise");

        // R10: shutdown passes through and keeps codes
        shdn_n = 1'b0;
        wait_clk(4);
        checks++;
        if (pd_n !== 1'b0) begin
            fails++;
            $display("FAIL R10 pd_n: got %b expected 0", pd_n);
        end
        check_all("R10 codes during shutdown");
        shdn_n = 1'b1;
        wait_clk(2);
        checks++;
        if (pd_n !== 1'b1) begin
            fails++;
            $display("FAIL R10 pd_n release: got %b expected 1", pd_n);
        end

        // R5: asynchronous preset, seen before any clock edge
        @(posedge clk);
        #2 preset_n = 1'b0;
        #1;
        set_mid();
        check_all("R5 preset without clock edge");
        wait_clk(3);
        check_all("R5 preset held");
        preset_n = 1'b1;
        wait_clk(3);
        send(4'd9, 8'h01, 12);
        exp_code[9] = 8'h01;
        check_all("R2 write after preset");

        summary();
    end
endmodule